// File: doc/BRIEF.md
# Quarter-Cycle Iterative Shift and Rotate Engine

This block sits behind a datapath adder and performs multi-position shifts and rotates with a gate stage that can move a word by only one bit per pass. A request names a direction, shift or rotate, single or paired operation, a position count and two 16-bit operands, the accumulator word A and the extension word X. In single mode only A moves, by 1 to 8 positions; in paired mode A and X form one 32-bit chain (A the upper half) that moves by 1 to 16 positions. A paired position is done as two passes, first A and then X, with the bit that leaves one word carried into the other through a one-bit link register.

Every clock cycle of the engine stands for one quarter of a base instruction cycle. A request spends three setup quarters, then one quarter per pass. A single shift therefore lasts N+3 quarters (4, 5, 6 for N = 1, 2, 3), a paired shift 2N+3 quarters (5, 7, 9), and the engine reports that length on its quarter counter when it signals completion. A request with a count of zero or above the mode's limit is refused with an error pulse.

The controller moves through four named states. IDLE waits for a strobe; an accepted strobe takes it to SETUP, which holds for three cycles and then goes to PASS_A. PASS_A shifts A one bit; in single mode it stays in PASS_A until the last position and then returns to IDLE, in paired mode it always goes to PASS_X. PASS_X shifts X one bit and goes back to PASS_A, or to IDLE after the last position.

Top module: `qshift_top`

## Requirements
- R1: After reset a_out, x_out and quarters are 0 and busy, done and err are low.
- R2: With rotate=0 and pair_mode=0, A is shifted by count positions, left when dir_left=1 and right when dir_left=0, with zeros entering; x_out keeps the loaded x_in.
- R3: With rotate=1 and pair_mode=0, A is rotated by count positions in the chosen direction, the bit leaving one end entering the other; x_out keeps the loaded x_in.
- R4: With rotate=0 and pair_mode=1, the 32-bit chain {A,X} is shifted by count positions with zeros entering; on a left shift X bit 15 enters A bit 0, on a right shift A bit 0 enters X bit 15.
- R5: With rotate=1 and pair_mode=1, the 32-bit chain {A,X} is rotated by count positions.
- R6: A single-mode request ends with quarters = count+3, and done rises exactly count+3 clock edges after the edge that accepted the strobe.
- R7: A paired request ends with quarters = 2*count+3, and done rises exactly 2*count+3 clock edges after the accepting edge.
- R8: A strobe whose count (an unsigned 5-bit value) is 0, or above 8 in single mode, or above 16 in paired mode, produces a one-cycle err pulse on the next edge, no done and no busy, and leaves a_out, x_out and quarters unchanged.
- R9: A strobe that arrives while busy is high is ignored: the running request completes with its own operands and timing.
- R10: busy is high from the accepting edge until done; done is a one-cycle pulse and is never high together with err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one quarter of a base cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled while idle |
| dir_left | input | 1 | 1 = left, 0 = right |
| rotate | input | 1 | 1 = rotate, 0 = zero-filling shift |
| pair_mode | input | 1 | 1 = paired A:X chain, 0 = A alone |
| count | input | 5 | Number of positions |
| a_in | input | 16 | Accumulator operand |
| x_in | input | 16 | Extension operand |
| a_out | output | 16 | Accumulator result |
| x_out | output | 16 | Extension result |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| quarters | output | 6 | Quarters spent by the last accepted request |

## Verification
The engine is driven with random directions, modes, counts and operands, so that single and paired moves, shifts and rotates in both directions are each compared with a bench model; rotates tell a wrapped end bit from a zero fill, and paired moves show whether the bit crossing between A and X is carried by the link in the right order. Directed cases take the counts 1 and the mode limits, where the quarter total separates the N+3 and 2N+3 formulas from an off-by-one, and the refused counts 0, 9 in single mode and 17 in paired mode. A strobe with different operands sent mid-request shows whether the busy engine ignores it.

// File: rtl/qshift_pkg.sv
package qshift_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PASS_A,
        ST_PASS_X
    } qs_state_t;

    typedef struct packed {
        logic left;
        logic rot;
        logic pair;
    } qs_mode_t;

endpackage

// File: rtl/qshift_gate.sv
module qshift_gate #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         en,
    input  logic         left,
    input  logic         fill,
    output logic [W-1:0] dout,
    output logic         spill
);
    // One-bit move per pass, or data passed unchanged when not enabled.
    always_comb begin
        spill = left ? din[W-1] : din[0];
        if (!en)
            dout = din;
        else if (left)
            dout = {din[W-2:0], fill};
        else
            dout = {fill, din[W-1:1]};
    end
endmodule

// File: rtl/qshift_timer.sv
module qshift_timer #(
    parameter int QW   = 6,
    parameter int QMAX = 35
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic [QW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (clear)
            q <= '0;
        else if (tick)
            q <= q + 1'b1;
    end

    // R7: the quarter count never runs past the longest legal request
    assert_quarter_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q <= QW'(QMAX));
endmodule

// File: rtl/qshift_ctrl.sv
module qshift_ctrl
    import qshift_pkg::*;
#(
    parameter int CW         = 5,
    parameter int SINGLE_MAX = 8,
    parameter int DOUBLE_MAX = 16,
    parameter int SETUP_Q    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          left,
    input  logic          rot,
    input  logic          pair,
    input  logic [CW-1:0] count,
    output qs_mode_t      mode_q,
    output logic          load,
    output logic          pass_a,
    output logic          pass_x,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam int SW = $clog2(SETUP_Q + 1);
    localparam logic [CW-1:0] LIM_S = CW'(SINGLE_MAX);
    localparam logic [CW-1:0] LIM_D = CW'(DOUBLE_MAX);
    localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_Q - 1);

    qs_state_t     state, nxt;
    logic [CW-1:0] rem;
    logic [SW-1:0] setup_ctr;
    logic          valid, accept, reject, pos_end, last_pass;

    always_comb begin
        valid     = (count != '0) && (count <= (pair ? LIM_D : LIM_S));
        accept    = start && (state == ST_IDLE) && valid;
        reject    = start && (state == ST_IDLE) && !valid;
        pos_end   = ((state == ST_PASS_A) && !mode_q.pair) || (state == ST_PASS_X);
        last_pass = pos_end && (rem == CW'(1));
        load      = accept;
        pass_a    = (state == ST_PASS_A);
        pass_x    = (state == ST_PASS_X);
        busy      = (state != ST_IDLE);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_SETUP;
            ST_SETUP:  if (setup_ctr == SETUP_LAST) nxt = ST_PASS_A;
            ST_PASS_A: begin
                if (mode_q.pair)
                    nxt = ST_PASS_X;
                else if (rem == CW'(1))
                    nxt = ST_IDLE;
            end
            ST_PASS_X: nxt = (rem == CW'(1)) ? ST_IDLE : ST_PASS_A;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Request latch, remaining positions, setup counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            rem       <= '0;
            setup_ctr <= '0;
        end else if (accept) begin
            mode_q    <= '{left: left, rot: rot, pair: pair};
            rem       <= count;
            setup_ctr <= '0;
        end else begin
            if (state == ST_SETUP)
                setup_ctr <= setup_ctr + 1'b1;
            if (pos_end)
                rem <= rem - 1'b1;
        end
    end

    // Output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= last_pass;
            err  <= reject;
        end
    end

    // R10: completion and refusal are exclusive
    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: work only begins after a strobe
    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R7: the X pass exists only in paired mode
    assert_pass_x_paired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS_X) |-> mode_q.pair);
    // R8: a running request always holds a legal position count
    assert_rem_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem != '0) && (rem <= (mode_q.pair ? LIM_D : LIM_S)));
endmodule

// File: rtl/qshift_top.sv
module qshift_top
    import qshift_pkg::*;
#(
    parameter int W          = 16,
    parameter int SINGLE_MAX = 8,
    parameter int DOUBLE_MAX = 16,
    parameter int SETUP_Q    = 3,
    localparam int CW        = $clog2(DOUBLE_MAX + 1),
    localparam int QMAX      = 2 * DOUBLE_MAX + SETUP_Q,
    localparam int QW        = $clog2(QMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_left,
    input  logic          rotate,
    input  logic          pair_mode,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  x_in,
    output logic [W-1:0]  a_out,
    output logic [W-1:0]  x_out,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [QW-1:0] quarters
);
    qs_mode_t     mode_q;
    logic         load, pass_a, pass_x;
    logic [W-1:0] a_reg, x_reg, a_next, x_next;
    logic         link, a_spill, x_spill, fill_a, fill_x;

    qshift_ctrl #(
        .CW(CW), .SINGLE_MAX(SINGLE_MAX), .DOUBLE_MAX(DOUBLE_MAX), .SETUP_Q(SETUP_Q)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .left(dir_left), .rot(rotate), .pair(pair_mode), .count(count),
        .mode_q(mode_q), .load(load), .pass_a(pass_a), .pass_x(pass_x),
        .busy(busy), .done(done), .err(err)
    );

    qshift_timer #(.QW(QW), .QMAX(QMAX)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(load), .tick(busy), .q(quarters)
    );

    // Incoming bit for each word's pass
    always_comb begin
        if (mode_q.pair)
            fill_a = mode_q.left ? x_reg[W-1] : (mode_q.rot & x_reg[0]);
        else
            fill_a = mode_q.rot & a_spill;
        fill_x = mode_q.left ? (mode_q.rot & link) : link;
    end

    qshift_gate #(.W(W)) u_gate_a (
        .din(a_reg), .en(pass_a), .left(mode_q.left), .fill(fill_a),
        .dout(a_next), .spill(a_spill)
    );

    qshift_gate #(.W(W)) u_gate_x (
        .din(x_reg), .en(pass_x), .left(mode_q.left), .fill(fill_x),
        .dout(x_next), .spill(x_spill)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_reg <= '0;
            x_reg <= '0;
            link  <= 1'b0;
        end else if (load) begin
            a_reg <= a_in;
            x_reg <= x_in;
            link  <= 1'b0;
        end else begin
            if (pass_a) begin
                a_reg <= a_next;
                link  <= a_spill;
            end
            if (pass_x)
                x_reg <= x_next;
        end
    end

    assign a_out = a_reg;
    assign x_out = x_reg;

    // R2: a single-mode pass never disturbs X
    assert_single_x_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_a && !mode_q.pair) |=> $stable(x_reg));
    // R3: a single rotate pass keeps the number of ones in A
    assert_rot_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_a && !mode_q.pair && mode_q.rot) |=> ($countones(a_reg) == $past($countones(a_reg))));
    // R5: a full paired rotate position keeps the ones of the chain
    assert_dbl_rot_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_x && mode_q.rot) |=> ($countones({a_reg, x_reg}) == $past($countones({a_reg, x_reg}), 2)));
    // R8: a refusal leaves results and timing untouched
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(a_reg) && $stable(x_reg) && $stable(quarters)));
    // R6: no request completes faster than setup plus one pass
    assert_done_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quarters >= QW'(SETUP_Q + 1)));
endmodule

// File: tb/sim_qshift_top.sv
`timescale 1ns/1ps
module sim_qshift_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_left = 1'b0, rotate = 1'b0, pair_mode = 1'b0;
    logic [4:0]  count = '0;
    logic [15:0] a_in = '0, x_in = '0;
    logic [15:0] a_out, x_out;
    logic        busy, done, err;
    logic [5:0]  quarters;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    qshift_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_left(dir_left),
        .rotate(rotate), .pair_mode(pair_mode), .count(count),
        .a_in(a_in), .x_in(x_in), .a_out(a_out), .x_out(x_out),
        .busy(busy), .done(done), .err(err), .quarters(quarters)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input bit l, input bit r, input bit p,
                                          input int n, input logic [15:0] a,
                                          input logic [15:0] x);
        logic [31:0] v;
        logic [15:0] s;
        v = {a, x};
        s = a;
        for (int i = 0; i < n; i++) begin
            if (p) begin
                if (l) v = {v[30:0], r ? v[31] : 1'b0};
                else   v = {r ? v[0] : 1'b0, v[31:1]};
            end else begin
                if (l) s = {s[14:0], r ? s[15] : 1'b0};
                else   s = {r ? s[0] : 1'b0, s[15:1]};
            end
        end
        return p ? v : {s, x};
    endfunction

    function automatic string rtag(input bit r, input bit p);
        if (p) return r ? "R5" : "R4";
        return r ? "R3" : "R2";
    endfunction

    task automatic run_op(input bit l, input bit r, input bit p, input int n,
                          input logic [15:0] a, input logic [15:0] x, input bit poke);
        logic [31:0] exp;
        int lat;
        bit seen;
        exp = model(l, r, p, n, a, x);
        @(negedge clk);
        dir_left = l; rotate = r; pair_mode = p; count = 5'(n);
        a_in = a; x_in = x; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after accept", {31'd0, busy}, 32'd1);
        lat = 0;
        seen = 0;
        while (!seen && lat < 200) begin
            if (poke && lat == 2) begin
                start = 1'b1; dir_left = ~l; rotate = ~r; count = 5'd1;
                a_in = ~a; x_in = ~x;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (done) seen = 1;
        end
        if (!seen) begin
            chk("R10 done never seen", 32'd0, 32'd1);
        end else begin
            chk({rtag(r, p), " a_out"}, {16'd0, a_out}, {16'd0, exp[31:16]});
            chk({rtag(r, p), " x_out"}, {16'd0, x_out}, {16'd0, exp[15:0]});
            chk(p ? "R7 quarters" : "R6 quarters", {26'd0, quarters},
                p ? 32'(2 * n + 3) : 32'(n + 3));
            chk(p ? "R7 latency" : "R6 latency", 32'(lat), p ? 32'(2 * n + 3) : 32'(n + 3));
            chk("R10 no err with done", {31'd0, err}, 32'd0);
            @(negedge clk);
            chk("R10 done pulse", {31'd0, done}, 32'd0);
            chk("R10 busy cleared", {31'd0, busy}, 32'd0);
        end
    endtask

    task automatic reject_op(input bit p, input int n);
        logic [15:0] a0, x0;
        logic [5:0]  q0;
        @(negedge clk);
        a0 = a_out; x0 = x_out; q0 = quarters;
        dir_left = 1'b1; rotate = 1'b0; pair_mode = p; count = 5'(n);
        a_in = 16'hDEAD; x_in = 16'hBEEF; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R8 err pulse", {31'd0, err}, 32'd1);
        chk("R8 no done", {31'd0, done}, 32'd0);
        chk("R8 no busy", {31'd0, busy}, 32'd0);
        chk("R8 a_out held", {16'd0, a_out}, {16'd0, a0});
        chk("R8 x_out held", {16'd0, x_out}, {16'd0, x0});
        chk("R8 quarters held", {26'd0, quarters}, {26'd0, q0});
        @(negedge clk);
        chk("R8 err one cycle", {31'd0, err}, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        chk("R1 a_out reset", {16'd0, a_out}, 32'd0);
        chk("R1 x_out reset", {16'd0, x_out}, 32'd0);
        chk("R1 quarters reset", {26'd0, quarters}, 32'd0);
        chk("R1 flags reset", {29'd0, busy, done, err}, 32'd0);
        rst_n = 1'b1;

        // directed corners
        run_op(1, 0, 0, 1, 16'h8001, 16'h1234, 0);
        run_op(0, 0, 0, 8, 16'hF00F, 16'h5555, 0);
        run_op(1, 1, 0, 8, 16'h8421, 16'hAAAA, 0);
        run_op(0, 1, 0, 3, 16'h0007, 16'h0F0F, 0);
        run_op(1, 0, 1, 1, 16'h0001, 16'h8000, 0);
        run_op(0, 0, 1, 16, 16'hABCD, 16'h1357, 0);
        run_op(1, 1, 1, 16, 16'h1234, 16'hFEDC, 0);
        run_op(0, 1, 1, 1, 16'h8000, 16'h0001, 0);
        run_op(1, 1, 1, 3, 16'hC000, 16'h0003, 0);

        // refused counts
        reject_op(0, 0);
        reject_op(0, 9);
        reject_op(1, 0);
        reject_op(1, 17);
        reject_op(0, 31);

        // strobe while busy is ignored (R9)
        run_op(1, 0, 1, 5, 16'h0F0F, 16'hF0F0, 1);
        run_op(0, 1, 0, 6, 16'h1111, 16'h2222, 1);

        // constrained random mix
        for (int k = 0; k < 80; k++) begin
            bit l, r, p;
            int n;
            l = 1'($urandom);
            r = 1'($urandom);
            p = 1'($urandom);
            n = p ? int'($urandom_range(16, 1)) : int'($urandom_range(8, 1));
            run_op(l, r, p, n, 16'($urandom), 16'($urandom), 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule